// File: doc/BRIEF.md
# Four-Line Fixed-Assignment Interrupt Controller

This block gathers interrupt requests from four on-chip sources and presents one interrupt line to a processor. Each source has a fixed line number: the periodic timer is on line 0, the second serial port on line 3, the first serial port on line 4 and the network interface on line 5. A rising edge on a source latches a request. Requests pass through a per-line mask. The pending request with the highest priority drives the interrupt output, provided nothing of equal or higher priority is already being serviced.

The processor acknowledges with a one-cycle pulse. The block answers one cycle later with an 8-bit vector and a one-cycle valid strobe. There is no ready signal: the acknowledge pulse itself shows that the processor is ready to take the vector, so the vector path has no back-pressure. A small write-only register bus sets the mask and the vector base, and it accepts specific end-of-interrupt commands. Priorities are fixed, with a lower line number winning. The only way to clear an in-service bit is an end-of-interrupt command that names the line.

Top module: `quad_irq_ctrl`

## Requirements
- R1: After reset, irq_o and vec_vld_o are low, all four lines are masked, and the vector base is 0.
- R2: A rising edge on a source input sets that line's request. An input held high does not set a new request after the first one has been acknowledged.
- R3: The line numbers are fixed: timer is line 0, src_ser2_i is line 3, src_ser1_i is line 4 and src_nic_i is line 5. The low 3 bits of an answered vector equal the line number.
- R4: Among pending unmasked requests, the lowest line number is served first.
- R5: A pending request is forwarded only while no line with an equal or lower line number is in service. A line with a lower number than every in-service line is forwarded.
- R6: Acknowledge behaviour:
  - An acknowledge of a forwarded request produces vec_vld_o high for exactly the next cycle, with vec_o = {base, line}.
  - It clears that line's request and sets its in-service bit.
- R7: irq_o is low in any cycle where ack_i is high. In the following cycle it is re-evaluated against the updated in-service state.
- R8: A masked request stays latched and does not raise irq_o. Clearing its mask bit raises irq_o if nothing else blocks it. Mask register (address 0): bit n set masks line n.
- R9: A specific end-of-interrupt clears the in-service bit of the line it names. EOI command (address 2): data bit 6 = 1, data bits 2:0 = line.
- R10: An EOI write with data bit 6 = 0 (non-specific), or one that names a line not in {0,3,4,5}, leaves all state unchanged.
- R11: An acknowledge with no forwardable request returns vec_o = {base, 3'b111} with vec_vld_o, and it changes no request or in-service state.
- R12: A write to address 1 sets the vector base to data bits 7:3. Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tmr_i | input | 1 | Timer request (line 0) |
| src_ser1_i | input | 1 | First serial port request (line 4) |
| src_ser2_i | input | 1 | Second serial port request (line 3) |
| src_nic_i | input | 1 | Network interface request (line 5) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 mask, 1 base, 2 EOI |
| wr_data_i | input | 8 | Register write data |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_vld_o | output | 1 | Vector valid, one cycle after ack_i |
| vec_o | output | 8 | Interrupt vector {base, line} |

## Verification
The bench builds the block with its default parameters: four slots, 3-bit line numbers and an 8-bit vector. This puts the whole priority ladder within reach. Every ordering of in-service and pending lines can therefore be set up, including nesting a higher line under a lower one and blocking an equal or lower one. A behavioural model of the request, in-service, mask and base state is checked against irq_o, vec_vld_o and vec_o on every clock. The vector base uses a non-zero pattern so that the base and line fields of the vector are checked separately.

// File: rtl/qic_pkg.sv
package qic_pkg;
  localparam int LINE_W = 3;
  localparam int VEC_W  = 8;
  localparam int BASE_W = VEC_W - LINE_W;
  localparam int EOI_SPEC_BIT = 6;
  localparam logic [LINE_W-1:0] SPURIOUS_LINE = '1;

  typedef enum logic [1:0] {
    RA_MASK = 2'd0,
    RA_BASE = 2'd1,
    RA_EOI  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  // slot index -> fixed line number; slots are ordered by priority
  function automatic logic [LINE_W-1:0] slot_line(input int s);
    case (s)
      0:       slot_line = 3'd0;
      1:       slot_line = 3'd3;
      2:       slot_line = 3'd4;
      default: slot_line = 3'd5;
    endcase
  endfunction
endpackage

// File: rtl/qic_edge_latch.sv
module qic_edge_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= src_i;
      req_q  <= (req_q & ~clr_i) | (src_i & ~prev_q);
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/qic_regs.sv
module qic_regs
  import qic_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [VEC_W-1:0]  wr_data_i,
  output logic [N-1:0]      mask_o,
  output logic [BASE_W-1:0] base_o,
  output logic [N-1:0]      eoi_clr_o
);
  logic [N-1:0]      mask_q;
  logic [BASE_W-1:0] base_q;
  logic              wr_mask, wr_base, wr_eoi;

  assign wr_mask = wr_en_i && (reg_addr_e'(wr_addr_i) == RA_MASK);
  assign wr_base = wr_en_i && (reg_addr_e'(wr_addr_i) == RA_BASE);
  assign wr_eoi  = wr_en_i && (reg_addr_e'(wr_addr_i) == RA_EOI)
                   && wr_data_i[EOI_SPEC_BIT];

  generate
    for (genvar s = 0; s < N; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)       mask_q[s] <= 1'b1;
        else if (wr_mask) mask_q[s] <= wr_data_i[slot_line(s)];
      end
      assign eoi_clr_o[s] = wr_eoi && (wr_data_i[LINE_W-1:0] == slot_line(s));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= '0;
    else if (wr_base) base_q <= wr_data_i[VEC_W-1:LINE_W];
  end

  assign mask_o = mask_q;
  assign base_o = base_q;
endmodule

// File: rtl/qic_resolver.sv
module qic_resolver #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] isr_i,
  output logic         fwd_o,
  output logic [N-1:0] sel_o
);
  logic [N-1:0] pend;
  assign pend = req_i & ~mask_i;

  always_comb begin
    logic hit;
    logic busy;
    hit   = 1'b0;
    busy  = 1'b0;
    fwd_o = 1'b0;
    sel_o = '0;
    for (int s = 0; s < N; s++) begin
      busy = busy | isr_i[s];
      if (!hit && pend[s]) begin
        hit      = 1'b1;
        sel_o[s] = 1'b1;
        fwd_o    = !busy;
      end
    end
  end
endmodule

// File: rtl/quad_irq_ctrl.sv
module quad_irq_ctrl
  import qic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tmr_i,
  input  logic             src_ser1_i,
  input  logic             src_ser2_i,
  input  logic             src_nic_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [VEC_W-1:0] wr_data_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic             vec_vld_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int N = 4;

  logic [N-1:0]      src, req_q, mask_q, isr_q, eoi_clr, sel, take;
  logic [BASE_W-1:0] base_q;
  logic              fwd, grant;
  logic [LINE_W-1:0] sel_line;
  logic              vld_q;
  logic [VEC_W-1:0]  vec_q;

  // slot order equals priority order
  assign src = {src_nic_i, src_ser1_i, src_ser2_i, src_tmr_i};

  qic_edge_latch #(.N(N)) u_latch (
    .clk(clk), .rst_n(rst_n), .src_i(src), .clr_i(take), .req_o(req_q)
  );

  qic_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .mask_o(mask_q), .base_o(base_q),
    .eoi_clr_o(eoi_clr)
  );

  qic_resolver #(.N(N)) u_res (
    .req_i(req_q), .mask_i(mask_q), .isr_i(isr_q), .fwd_o(fwd), .sel_o(sel)
  );

  assign grant = ack_i && fwd;
  assign take  = grant ? sel : '0;

  always_comb begin
    sel_line = SPURIOUS_LINE;
    for (int s = 0; s < N; s++)
      if (grant && sel[s]) sel_line = slot_line(s);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
      vld_q <= 1'b0;
      vec_q <= '0;
    end else begin
      isr_q <= (isr_q & ~eoi_clr) | take;
      vld_q <= ack_i;
      if (ack_i) vec_q <= {base_q, sel_line};
    end
  end

  assign irq_o     = fwd && !ack_i;
  assign vec_vld_o = vld_q;
  assign vec_o     = vec_q;
endmodule

// File: rtl/quad_irq_ctrl_chk.sv
module quad_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_i,
  input logic       irq_o,
  input logic       vec_vld_o,
  input logic [7:0] vec_o,
  input logic [4:0] base_q,
  input logic [3:0] req_q,
  input logic [3:0] mask_q,
  input logic [3:0] isr_q
);
  a_r7_irq_low_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |-> !irq_o);

  a_r6_vld_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vec_vld_o);

  a_r6_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !vec_vld_o);

  a_r8_irq_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((req_q & ~mask_q) != 4'b0));

  a_r5_top_line_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
    isr_q[0] |-> !irq_o);

  a_r12_vec_base: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_vld_o && !$fell(rst_n)) |-> (vec_o[7:3] == $past(base_q)));
endmodule

bind quad_irq_ctrl quad_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .irq_o(irq_o),
  .vec_vld_o(vec_vld_o), .vec_o(vec_o), .base_q(base_q),
  .req_q(req_q), .mask_q(mask_q), .isr_q(isr_q)
);

// File: tb/quad_irq_ctrl_tb.sv
module quad_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src = 4'b0;     // slot order: tmr, ser2, ser1, nic
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       ack = 1'b0;
  logic       irq, vld;
  logic [7:0] vec;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural model
  int lines [4] = '{0, 3, 4, 5};
  int m_req [4];
  int m_isr [4];
  int m_prev [4];
  int m_mask;
  int m_base;
  int e_vld;
  int e_vec;

  always #10 clk = ~clk;

  quad_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .src_tmr_i(src[0]), .src_ser1_i(src[2]), .src_ser2_i(src[1]),
    .src_nic_i(src[3]),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ack_i(ack), .irq_o(irq), .vec_vld_o(vld), .vec_o(vec)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int m_sel();
    int busy = 0;
    for (int s = 0; s < 4; s++) begin
      if (m_isr[s] != 0) busy = 1;
      if (m_req[s] != 0 && ((m_mask >> lines[s]) & 1) == 0)
        return busy ? -1 : s;
    end
    return -1;
  endfunction

  function automatic void m_reset();
    for (int s = 0; s < 4; s++) begin
      m_req[s] = 0; m_isr[s] = 0; m_prev[s] = 0;
    end
    m_mask = 255; m_base = 0; e_vld = 0; e_vec = 0;
  endfunction

  function automatic void m_step();
    int sel = m_sel();
    if (wr_en && wr_addr == 2 && wr_data[6])
      for (int s = 0; s < 4; s++)
        if (lines[s] == int'(wr_data[2:0])) m_isr[s] = 0;
    if (ack) begin
      e_vld = 1;
      e_vec = (m_base << 3) | ((sel >= 0) ? lines[sel] : 7);
      if (sel >= 0) begin
        m_req[sel] = 0;
        m_isr[sel] = 1;
      end
    end else e_vld = 0;
    for (int s = 0; s < 4; s++) begin
      if (src[s] && m_prev[s] == 0) m_req[s] = 1;
      m_prev[s] = src[s];
    end
    if (wr_en && wr_addr == 0) m_mask = wr_data;
    if (wr_en && wr_addr == 1) m_base = wr_data[7:3];
  endfunction

  // inputs are set just after a falling edge; compare irq, clock, compare vector
  task automatic tick(input string tag);
    #2;
    chk(tag, "irq", irq, ((m_sel() >= 0) && !ack) ? 1 : 0);
    @(posedge clk);
    m_step();
    @(negedge clk);
    chk(tag, "vld", vld, e_vld);
    chk(tag, "vec", vec, e_vec);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic wr(input string tag, input int a, input int d);
    wr_en = 1; wr_addr = 2'(a); wr_data = 8'(d);
    tick(tag);
    wr_en = 0;
  endtask

  task automatic do_ack(input string tag);
    ack = 1;
    tick(tag);
    ack = 0;
  endtask

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    chk("R1", "irq", irq, 0);
    chk("R1", "vld", vld, 0);
    rst_n = 1;
    idle("R1", 2);
    // R1: reset mask hides a timer edge
    src[0] = 1; idle("R1", 3);
    chk("R1", "irq masked", irq, 0);
    // R12: base and ignored address 3
    wr("R12", 1, 8'hA8);
    wr("R12", 3, 8'hFF);
    // R8: unmask releases the latched timer request
    wr("R8", 0, 8'h00);
    idle("R8", 1);
    chk("R8", "irq after unmask", irq, 1);
    // R6 R3 R7: acknowledge timer
    do_ack("R7");
    chk("R3", "timer vector", vec, 8'hA8);
    // R2: level held high gives no new request
    idle("R2", 3);
    chk("R2", "no rearm", irq, 0);
    src[0] = 0;
    // R5: nic blocked while line 0 in service
    src[3] = 1; idle("R5", 3);
    chk("R5", "blocked", irq, 0);
    wr("R9", 2, 8'h40);
    chk("R9", "irq after eoi", irq, 1);
    do_ack("R6");
    chk("R3", "nic vector", vec, 8'hAD);
    src[3] = 0;
    // R5: line 3 nests over line 5
    src[1] = 1; idle("R5", 2);
    chk("R5", "nested", irq, 1);
    do_ack("R3");
    chk("R3", "ser2 vector", vec, 8'hAB);
    src[1] = 0;
    src[2] = 1; idle("R5", 2);
    chk("R5", "line4 blocked by 3", irq, 0);
    // R10: non-specific and unused-line EOIs do nothing
    wr("R10", 2, 8'h03);
    wr("R10", 2, 8'h42);
    wr("R10", 2, 8'h47);
    idle("R10", 1);
    chk("R10", "still blocked", irq, 0);
    wr("R9", 2, 8'h43);
    chk("R9", "line4 released", irq, 1);
    do_ack("R6");
    chk("R3", "ser1 vector", vec, 8'hAC);
    src[2] = 0;
    wr("R9", 2, 8'h44);
    wr("R9", 2, 8'h45);
    // R11: spurious acknowledge
    do_ack("R11");
    chk("R11", "spurious vector", vec, 8'hAF);
    idle("R11", 1);
    // R4: all four at once, masked, then released
    wr("R4", 0, 8'hFF);
    src = 4'hF; idle("R4", 2); src = 4'h0;
    wr("R4", 1, 8'h30);
    wr("R4", 0, 8'h00);
    do_ack("R4"); chk("R4", "first", vec, 8'h30);
    wr("R4", 2, 8'h40);
    do_ack("R4"); chk("R4", "second", vec, 8'h33);
    wr("R4", 2, 8'h43);
    do_ack("R4"); chk("R4", "third", vec, 8'h34);
    wr("R4", 2, 8'h44);
    do_ack("R4"); chk("R4", "fourth", vec, 8'h35);
    wr("R4", 2, 8'h45);
    // R8: masked timer stays latched, ser1 served
    wr("R8", 0, 8'h01);
    src[0] = 1; idle("R8", 2);
    chk("R8", "masked timer", irq, 0);
    src[2] = 1; idle("R8", 2);
    do_ack("R8"); chk("R8", "ser1 while timer masked", vec, 8'h34);
    wr("R9", 2, 8'h44);
    wr("R8", 0, 8'h00);
    do_ack("R8"); chk("R8", "timer kept latched", vec, 8'h30);
    src = 4'h0;
    wr("R9", 2, 8'h40);
    idle("R1", 3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule